// File: doc/BRIEF.md
# Quadrature Bus Clock Generator

This block turns a fast input clock into two bus clocks, E and Q, that run at one quarter of the input rate. Both are square waves with a 50% duty cycle. Q runs one input tick, which is a quarter of a bus cycle, ahead of E. A two-bit quarter counter drives both waves. The counter is decoded into three single-tick strobes that mark the key points of each bus cycle: the precharge quarter, the tick where the address becomes valid, and the tick where data is captured.

Every output comes straight from a flip-flop clocked by the fast input, so each downstream load sees a clean, glitch-free edge. Reset puts the counter in its last quarter with both waves low. After reset is released, the first input edge starts a new bus cycle at once.

Top module: `quad_busclk_gen`

## Requirements
- R1: While `rst_n` is low, `quarter_o` reads 3 and `clk_e_o`, `clk_q_o`, `precharge_o`, `addr_valid_o` and `data_capture_o` are all 0.
- R2: After reset, `quarter_o` steps by one on every rising edge of `clk_4x_i` in the order 0, 1, 2, 3 and then wraps to 0.
- R3: `clk_q_o` is 1 exactly in quarters 0 and 1.
- R4: `clk_e_o` is 1 exactly in quarters 1 and 2. Together with R3, each wave is high for 2 of every 4 input ticks, and Q rises one tick before E.
- R5: `addr_valid_o` is 1 for exactly one tick per bus cycle: the tick in which `clk_q_o` has just gone from 0 to 1 (quarter 0).
- R6: `data_capture_o` is 1 for exactly one tick per bus cycle: the tick in which `clk_e_o` has just gone from 1 to 0 (quarter 3). It is never 1 in the reset state.
- R7: `precharge_o` is 1 in quarter 0 only. Quarters 1 to 3 are the evaluate window.
- R8: On the first rising edge of `clk_4x_i` after `rst_n` goes high, `quarter_o` becomes 0 and `clk_q_o` and `addr_valid_o` become 1. This also holds after a reset applied in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_4x_i | input | 1 | Input clock at four times the bus rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_e_o | output | 1 | E bus clock, the lagging wave |
| clk_q_o | output | 1 | Q bus clock, leads E by one quarter |
| quarter_o | output | 2 | Current quarter of the bus cycle, 0 to 3 |
| precharge_o | output | 1 | High during the precharge quarter |
| addr_valid_o | output | 1 | One-tick strobe on the rising edge of Q |
| data_capture_o | output | 1 | One-tick strobe on the falling edge of E |

## Verification
Each output is one register away from the quarter count. Every output therefore takes its new value at the same rising edge that advances the quarter, or in the case of reset, at the first edge after the reset is sampled. The bench keeps a reference quarter and a count of ticks since reset, and updates both at each rising edge from the requirements alone. It compares every output on the following falling edge, and changes the reset input only after that comparison. Reset pulses of random length and at random times check that the restart and the no-strobe-in-reset rules hold whatever quarter the counter was in.

// File: rtl/quad_busclk_pkg.sv
package quad_busclk_pkg;

    parameter int unsigned QTR_W = 2;
    localparam int unsigned QTR_N = 1 << QTR_W;

    localparam logic [QTR_W-1:0] QTR_PRECHARGE = QTR_W'(0);
    localparam logic [QTR_W-1:0] QTR_E_RISE    = QTR_W'(1);
    localparam logic [QTR_W-1:0] QTR_Q_FALL    = QTR_W'(2);
    localparam logic [QTR_W-1:0] QTR_LAST      = QTR_W'(QTR_N - 1);

    typedef logic [QTR_W-1:0] quarter_t;

    typedef struct packed {
        quarter_t qtr;
        logic     e;
        logic     q;
        logic     pre;
        logic     addr;
        logic     cap;
    } busclk_state_t;

endpackage

// File: rtl/quad_busclk_counter.sv
module quad_busclk_counter
    import quad_busclk_pkg::*;
(
    input  quarter_t qtr_i,
    output quarter_t qtr_nx_o
);

    always_comb begin
        if (qtr_i == QTR_LAST) begin
            qtr_nx_o = '0;
        end else begin
            qtr_nx_o = qtr_i + QTR_W'(1);
        end
    end

endmodule

// File: rtl/quad_busclk_decode.sv
module quad_busclk_decode
    import quad_busclk_pkg::*;
(
    input  quarter_t qtr_i,
    output logic     e_o,
    output logic     q_o,
    output logic     pre_o,
    output logic     addr_o,
    output logic     cap_o
);

    always_comb begin
        q_o    = (qtr_i == QTR_PRECHARGE) || (qtr_i == QTR_E_RISE);
        e_o    = (qtr_i == QTR_E_RISE) || (qtr_i == QTR_Q_FALL);
        pre_o  = (qtr_i == QTR_PRECHARGE);
        addr_o = (qtr_i == QTR_PRECHARGE);
        cap_o  = (qtr_i == QTR_LAST);
    end

endmodule

// File: rtl/quad_busclk_gen.sv
module quad_busclk_gen
    import quad_busclk_pkg::*;
(
    input  logic             clk_4x_i,
    input  logic             rst_n,
    output logic             clk_e_o,
    output logic             clk_q_o,
    output logic [QTR_W-1:0] quarter_o,
    output logic             precharge_o,
    output logic             addr_valid_o,
    output logic             data_capture_o
);

    busclk_state_t st_d;
    busclk_state_t st_q;
    quarter_t      qtr_nx;
    logic          dec_e;
    logic          dec_q;
    logic          dec_pre;
    logic          dec_addr;
    logic          dec_cap;

    quad_busclk_counter u_counter (
        .qtr_i    (st_q.qtr),
        .qtr_nx_o (qtr_nx)
    );

    quad_busclk_decode u_decode (
        .qtr_i  (qtr_nx),
        .e_o    (dec_e),
        .q_o    (dec_q),
        .pre_o  (dec_pre),
        .addr_o (dec_addr),
        .cap_o  (dec_cap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.qtr  = qtr_nx;
        st_d.e    = dec_e;
        st_d.q    = dec_q;
        st_d.pre  = dec_pre;
        st_d.addr = dec_addr;
        st_d.cap  = dec_cap;
    end

    always_ff @(posedge clk_4x_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.qtr  <= QTR_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign quarter_o      = st_q.qtr;
    assign clk_e_o        = st_q.e;
    assign clk_q_o        = st_q.q;
    assign precharge_o    = st_q.pre;
    assign addr_valid_o   = st_q.addr;
    assign data_capture_o = st_q.cap;

    p_quarter_step_r2: assert property (@(posedge clk_4x_i) disable iff (!rst_n)
        1'b1 |=> (quarter_o == QTR_W'($past(quarter_o) + QTR_W'(1))));

    p_q_leads_e_r4: assert property (@(posedge clk_4x_i) disable iff (!rst_n)
        $rose(clk_e_o) |-> (clk_q_o && $past(clk_q_o)));

    p_addr_on_qrise_r5: assert property (@(posedge clk_4x_i) disable iff (!rst_n)
        addr_valid_o |-> ($rose(clk_q_o) && !$past(addr_valid_o)));

    p_cap_on_efall_r6: assert property (@(posedge clk_4x_i) disable iff (!rst_n)
        data_capture_o |-> ($fell(clk_e_o) && !clk_q_o));

    p_strobes_apart_r7: assert property (@(posedge clk_4x_i) disable iff (!rst_n)
        $onehot0({addr_valid_o, data_capture_o}) && (precharge_o == addr_valid_o));

endmodule

// File: tb/quad_busclk_gen_tb.sv
module quad_busclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_w, q_w, pre_w, addr_w, cap_w;
    logic [1:0] qtr_w;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [1:0] m_qtr = 2'd3;
    int         m_ticks = 0;
    logic       m_rst = 1'b1;

    always #4 clk = ~clk;

    quad_busclk_gen u_dut (
        .clk_4x_i       (clk),
        .rst_n          (rst_n),
        .clk_e_o        (e_w),
        .clk_q_o        (q_w),
        .quarter_o      (qtr_w),
        .precharge_o    (pre_w),
        .addr_valid_o   (addr_w),
        .data_capture_o (cap_w)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_qtr   <= 2'd3;
            m_ticks <= 0;
            m_rst   <= 1'b1;
        end else begin
            m_qtr   <= m_qtr + 2'd1;
            m_ticks <= m_ticks + 1;
            m_rst   <= 1'b0;
        end
    end

    function automatic logic exp_q(input logic [1:0] qq, input logic r);
        return !r && (qq == 2'd0 || qq == 2'd1);
    endfunction
    function automatic logic exp_e(input logic [1:0] qq, input logic r);
        return !r && (qq == 2'd1 || qq == 2'd2);
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_all();
        if (m_rst) begin
            chk("R1 quarter", qtr_w, 2'd3);
            chk("R1 outputs", {1'b0, e_w | q_w | pre_w | addr_w | cap_w}, 2'd0);
        end else begin
            chk("R2 quarter", qtr_w, m_qtr);
            chk("R3 clk_q", {1'b0, q_w}, {1'b0, exp_q(m_qtr, 1'b0)});
            chk("R4 clk_e", {1'b0, e_w}, {1'b0, exp_e(m_qtr, 1'b0)});
            chk("R5 addr_valid", {1'b0, addr_w}, {1'b0, m_qtr == 2'd0});
            chk("R6 data_capture", {1'b0, cap_w}, {1'b0, m_qtr == 2'd3 && m_ticks >= 4});
            chk("R7 precharge", {1'b0, pre_w}, {1'b0, m_qtr == 2'd0});
            if (m_ticks == 1) begin
                chk("R8 first tick", {q_w, addr_w}, 2'b11);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            check_all();
        end
        // directed: reset in each quarter, one tick long, then random traffic
        for (int k = 0; k < 4; k++) begin
            rst_n = 1'b0;
            @(negedge clk);
            check_all();
            rst_n = 1'b1;
            for (int j = 0; j < 9 + k; j++) begin
                @(negedge clk);
                check_all();
            end
        end
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            check_all();
            if ($urandom_range(0, 99) < 3) rst_n = 1'b0;
            else if (!rst_n && $urandom_range(0, 3) == 0) rst_n = 1'b1;
        end
        rst_n = 1'b1;
        repeat (8) begin
            @(negedge clk);
            check_all();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule